// File: doc/BRIEF.md
# Ping-Pong Loopback Buffer with Sequence Checker

This block is a loopback test engine for a bidirectional link. Words arriving from a slow return-path decoder are written into one of two block buffers. Meanwhile the buffer filled before it is read out onto a fast forward link. When the receiving buffer holds a full block and the forward side has finished its previous block, the two buffers exchange roles. The newest complete block is therefore always the next one sent forward.

On the forward link, each block is framed by a start control word and a stop control word, with the data words between them. A checker watches the words the block actually hands to the forward link. It treats the first data word of each block as the seed of a pseudo-random sequence, compares that seed with the seed the test harness expects, and verifies every later word against the sequence. It keeps a saturating error count, a sticky error flag and a count of completed blocks.

The block is used to soak-test a link pair. Software sends seeded blocks over the return path, and the hardware loops them back and reports any corruption it sees.

Top module: `pingpong_loopback`

## Requirements
- R1: After reset, `ret_ready` is 1, `fwd_valid` is 0, `err_count` and `blk_count` are 0 and `err_flag` is 0.
- R2: Return words are accepted on cycles where `ret_valid` and `ret_ready` are both 1. After BLK_LEN words, `ret_ready` stays 0 until that block can start draining. A new block can be accepted while an older block is still draining.
- R3: Blocks leave on the forward link in the order they were completed on the return side. A full block starts draining only after the previous block's stop word has been transferred.
- R4: Each block goes out in three parts, in this order:
  - a start control word 32'hB10C_0000 with `fwd_ctrl`=1;
  - the BLK_LEN data words, in arrival order, with `fwd_ctrl`=0;
  - a stop control word 32'hE10C_0000 with `fwd_ctrl`=1.
- R5: While `fwd_valid` is 1 and `fwd_ready` is 0, `fwd_valid`, `fwd_ctrl` and `fwd_data` hold their values on the next cycle.
- R6: Each data word after the seed must equal the next step of a 32-bit Galois LFSR taken from the previous expected word. One step is: shift right by one; if the bit shifted out was 1, XOR with 32'h8020_0003. Every mismatching word adds exactly 1 to `err_count`. The expected value advances regardless of the mismatch, so one bad word counts once.
- R7: The first data word of a block is compared with `exp_seed` as sampled on the cycle that word is transferred. A mismatch adds 1 to `err_count`. The later words of that block are checked against the sequence of the received seed.
- R8: `err_flag` becomes 1 with the first counted error and stays 1 until reset. `err_count` saturates at its maximum value, 2^ERR_W-1.
- R9: `blk_count` increments by one on each transferred stop control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Return-path word valid |
| ret_data | input | WORD_W | Return-path word |
| ret_ready | output | 1 | Block can take a return word |
| fwd_valid | output | 1 | Forward word valid |
| fwd_ctrl | output | 1 | Forward word is a control word |
| fwd_data | output | WORD_W | Forward word |
| fwd_ready | input | 1 | Forward link takes the word |
| exp_seed | input | WORD_W | Seed expected for the block being checked |
| err_count | output | ERR_W | Saturating error count |
| err_flag | output | 1 | Sticky error indication |
| blk_count | output | BLK_W | Count of forwarded blocks |

## Verification
The buffer read path is combinational. A drained word therefore appears on `fwd_data` in the same cycle its state is entered, and it is consumed at the next rising edge on which `fwd_ready` is 1. The bench sets `fwd_ready` just after each falling edge and then samples the forward port half a cycle before the edge that completes the transfer. Each transfer is compared in order against a queue of expected words built by the bench when it sends each block. `ret_ready` falls one edge after the last word of a block is taken, and `err_count` and `blk_count` change one edge after the word that causes them. For this reason the bench reads these outputs only after the forward queue has emptied and several idle cycles have passed.

// File: rtl/pplb_pkg.sv
package pplb_pkg;
   localparam logic [31:0] LFSR_TAPS  = 32'h8020_0003;
   localparam logic [31:0] MARK_BEGIN = 32'hB10C_0000;
   localparam logic [31:0] MARK_END   = 32'hE10C_0000;

   typedef enum logic [1:0] {
      DR_IDLE,
      DR_HEAD,
      DR_BODY,
      DR_TAIL
   } drain_st_e;

   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      logic [31:0] n;
      n = s >> 1;
      if (s[0]) n = n ^ LFSR_TAPS;
      return n;
   endfunction
endpackage

// File: rtl/pplb_bank_pair.sv
module pplb_bank_pair #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 256,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_bank,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] bank_word [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [WORD_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
      end
      assign bank_word[b] = mem[rd_addr];
   end

   assign rd_data = bank_word[rd_bank];
endmodule

// File: rtl/pplb_fill.sv
module pplb_fill #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 256,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   input  logic              swap,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              full
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] idx;
   logic          take;

   assign in_ready = !full;
   assign take     = in_valid && in_ready;
   assign wr_en    = take;
   assign wr_addr  = idx;
   assign wr_data  = in_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         full <= 1'b0;
      end else if (swap) begin
         full <= 1'b0;
      end else if (take) begin
         if (idx == LAST) begin
            idx  <= '0;
            full <= 1'b1;
         end else begin
            idx <= idx + AW'(1);
         end
      end
   end
endmodule

// File: rtl/pplb_drain.sv
module pplb_drain
   import pplb_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 256,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_bank,
   output logic              rd_bank,
   output logic [AW-1:0]     rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic              out_valid,
   output logic              out_ctrl,
   output logic [WORD_W-1:0] out_data,
   input  logic              out_ready,
   output logic              idle
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   drain_st_e     st;
   logic          bank;
   logic [AW-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= DR_IDLE;
         bank <= 1'b0;
         idx  <= '0;
      end else begin
         unique case (st)
            DR_IDLE: if (start) begin
               bank <= start_bank;
               idx  <= '0;
               st   <= DR_HEAD;
            end
            DR_HEAD: if (out_ready) st <= DR_BODY;
            DR_BODY: if (out_ready) begin
               if (idx == LAST) begin
                  idx <= '0;
                  st  <= DR_TAIL;
               end else begin
                  idx <= idx + AW'(1);
               end
            end
            DR_TAIL: if (out_ready) st <= DR_IDLE;
            default: st <= DR_IDLE;
         endcase
      end
   end

   assign idle      = (st == DR_IDLE);
   assign rd_bank   = bank;
   assign rd_addr   = idx;
   assign out_valid = (st != DR_IDLE);
   assign out_ctrl  = (st == DR_HEAD) || (st == DR_TAIL);

   always_comb begin
      unique case (st)
         DR_HEAD: out_data = MARK_BEGIN;
         DR_TAIL: out_data = MARK_END;
         default: out_data = rd_data;
      endcase
   end
endmodule

// File: rtl/pplb_seq_check.sv
module pplb_seq_check
   import pplb_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ERR_W  = 16,
   parameter int BLK_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_xfer,
   input  logic              mon_ctrl,
   input  logic [WORD_W-1:0] mon_data,
   input  logic [WORD_W-1:0] exp_seed,
   output logic [ERR_W-1:0]  err_count,
   output logic              err_flag,
   output logic [BLK_W-1:0]  blk_count
);
   logic              want_seed;
   logic [WORD_W-1:0] expect_q;
   logic [WORD_W-1:0] expect_n;
   logic              mismatch;
   logic              data_xfer;

   assign data_xfer = mon_xfer && !mon_ctrl;
   assign expect_n  = lfsr_next(expect_q);
   assign mismatch  = data_xfer && (want_seed ? (mon_data != exp_seed)
                                              : (mon_data != expect_n));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         want_seed <= 1'b0;
         expect_q  <= '0;
         err_count <= '0;
         err_flag  <= 1'b0;
         blk_count <= '0;
      end else begin
         if (mon_xfer && mon_ctrl && (mon_data == MARK_BEGIN)) want_seed <= 1'b1;
         if (mon_xfer && mon_ctrl && (mon_data == MARK_END))
            blk_count <= blk_count + BLK_W'(1);
         if (data_xfer) begin
            want_seed <= 1'b0;
            expect_q  <= want_seed ? mon_data : expect_n;
         end
         if (mismatch) begin
            err_flag <= 1'b1;
            if (err_count != '1) err_count <= err_count + ERR_W'(1);
         end
      end
   end
endmodule

// File: rtl/pingpong_loopback.sv
module pingpong_loopback
   import pplb_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int BLK_LEN = 256,
   parameter int ERR_W   = 16,
   parameter int BLK_W   = 16,
   localparam int AW     = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_valid,
   input  logic [WORD_W-1:0] ret_data,
   output logic              ret_ready,
   output logic              fwd_valid,
   output logic              fwd_ctrl,
   output logic [WORD_W-1:0] fwd_data,
   input  logic              fwd_ready,
   input  logic [WORD_W-1:0] exp_seed,
   output logic [ERR_W-1:0]  err_count,
   output logic              err_flag,
   output logic [BLK_W-1:0]  blk_count
);
   if (WORD_W != 32) begin : g_bad_width
      $error("pingpong_loopback: WORD_W must be 32 for the sequence generator");
   end
   if (BLK_LEN < 2) begin : g_bad_len
      $error("pingpong_loopback: BLK_LEN must be at least 2");
   end
   if (ERR_W < 1 || BLK_W < 1) begin : g_bad_cnt
      $error("pingpong_loopback: counter widths must be positive");
   end

   logic              fill_bank;
   logic              fill_full;
   logic              drain_idle;
   logic              swap;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [WORD_W-1:0] wr_data;
   logic              rd_bank;
   logic [AW-1:0]     rd_addr;
   logic [WORD_W-1:0] rd_data;

   assign swap = fill_full && drain_idle;

   always_ff @(posedge clk) begin
      if (!rst_n)    fill_bank <= 1'b0;
      else if (swap) fill_bank <= !fill_bank;
   end

   pplb_fill #(.WORD_W(WORD_W), .DEPTH(BLK_LEN)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .in_valid(ret_valid), .in_data(ret_data), .in_ready(ret_ready),
      .swap(swap), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .full(fill_full)
   );

   pplb_bank_pair #(.WORD_W(WORD_W), .DEPTH(BLK_LEN)) u_banks (
      .clk(clk), .wr_en(wr_en), .wr_bank(fill_bank), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   pplb_drain #(.WORD_W(WORD_W), .DEPTH(BLK_LEN)) u_drain (
      .clk(clk), .rst_n(rst_n), .start(swap), .start_bank(fill_bank),
      .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data),
      .out_valid(fwd_valid), .out_ctrl(fwd_ctrl), .out_data(fwd_data),
      .out_ready(fwd_ready), .idle(drain_idle)
   );

   pplb_seq_check #(.WORD_W(WORD_W), .ERR_W(ERR_W), .BLK_W(BLK_W)) u_check (
      .clk(clk), .rst_n(rst_n),
      .mon_xfer(fwd_valid && fwd_ready), .mon_ctrl(fwd_ctrl), .mon_data(fwd_data),
      .exp_seed(exp_seed), .err_count(err_count), .err_flag(err_flag),
      .blk_count(blk_count)
   );
endmodule

// File: rtl/pplb_loopback_sva.sv
module pplb_loopback_sva
   import pplb_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ERR_W  = 16,
   parameter int BLK_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ret_valid,
   input logic              ret_ready,
   input logic              fwd_valid,
   input logic              fwd_ready,
   input logic              fwd_ctrl,
   input logic [WORD_W-1:0] fwd_data,
   input logic [ERR_W-1:0]  err_count,
   input logic              err_flag,
   input logic [BLK_W-1:0]  blk_count
);
   // R2
   ready_drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ret_ready) |-> $past(ret_valid));

   // R4
   ctrl_word_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_ctrl) |-> (fwd_data == MARK_BEGIN || fwd_data == MARK_END));

   // R5
   fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_ctrl) && $stable(fwd_data)));

   // R6
   err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != $past(err_count)) |-> (err_count == $past(err_count) + ERR_W'(1)));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R8
   err_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag == (err_count != '0));

   // R9
   blk_count_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_count != $past(blk_count)) |->
         $past(fwd_valid && fwd_ready && fwd_ctrl && fwd_data == MARK_END));
endmodule

bind pingpong_loopback pplb_loopback_sva #(
   .WORD_W(WORD_W), .ERR_W(ERR_W), .BLK_W(BLK_W)
) u_sva (
   .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ready(ret_ready),
   .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_ctrl(fwd_ctrl),
   .fwd_data(fwd_data), .err_count(err_count), .err_flag(err_flag),
   .blk_count(blk_count)
);

// File: tb/pingpong_loopback_bench.sv
module pingpong_loopback_bench;
   localparam int W   = 32;
   localparam int L   = 8;
   localparam int EW  = 3;
   localparam int BW  = 16;
   localparam logic [31:0] BEGIN_W = 32'hB10C_0000;
   localparam logic [31:0] END_W   = 32'hE10C_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ret_valid = 1'b0;
   logic [W-1:0]  ret_data = '0;
   logic          ret_ready;
   logic          fwd_valid, fwd_ctrl;
   logic [W-1:0]  fwd_data;
   logic          fwd_ready = 1'b0;
   logic [W-1:0]  exp_seed = '0;
   logic [EW-1:0] err_count;
   logic          err_flag;
   logic [BW-1:0] blk_count;

   int  n_chk = 0, n_fail = 0;
   bit  hold = 1'b1, fast = 1'b0, mon_on = 1'b0, done = 1'b0;
   logic [32:0] expq[$];
   logic [31:0] seedq[$];

   always #10 clk = !clk;

   pingpong_loopback #(.WORD_W(W), .BLK_LEN(L), .ERR_W(EW), .BLK_W(BW)) u_pingpong_loopback (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_data(ret_data),
      .ret_ready(ret_ready), .fwd_valid(fwd_valid), .fwd_ctrl(fwd_ctrl),
      .fwd_data(fwd_data), .fwd_ready(fwd_ready), .exp_seed(exp_seed),
      .err_count(err_count), .err_flag(err_flag), .blk_count(blk_count)
   );

   function automatic logic [31:0] bstep(input logic [31:0] s);
      return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_word(input logic [31:0] w, input int gap);
      repeat (gap) @(negedge clk);
      @(negedge clk);
      ret_valid = 1'b1;
      ret_data  = w;
      forever begin
         if (ret_ready) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   // corrupt_mask bit i flips word i; bad_seed makes exp_seed disagree
   task automatic send_block(input logic [31:0] seed, input logic [L-1:0] corrupt_mask,
                             input bit bad_seed, input int maxgap);
      logic [31:0] w [L];
      logic [31:0] s;
      s = seed;
      for (int i = 0; i < L; i++) begin
         if (i > 0) s = bstep(s);
         w[i] = corrupt_mask[i] ? (s ^ 32'h0000_0010) : s;
      end
      seedq.push_back(bad_seed ? (seed ^ 32'h1) : seed);
      expq.push_back({1'b1, BEGIN_W});
      for (int i = 0; i < L; i++) expq.push_back({1'b0, w[i]});
      expq.push_back({1'b1, END_W});
      for (int i = 0; i < L; i++)
         send_word(w[i], (maxgap == 0) ? 0 : int'($urandom % (maxgap + 1)));
   endtask

   // forward-link sink and in-order comparison (R3, R4)
   initial begin
      logic [32:0] e;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            fwd_ready = hold ? 1'b0 : (fast ? 1'b1 : (($urandom % 10) < 7));
            #1;
            if (fwd_valid && fwd_ready) begin
               if (expq.size() == 0) begin
                  chk(1'b0, "R3 unexpected forward word", {fwd_ctrl, fwd_data}, 0);
               end else begin
                  e = expq.pop_front();
                  chk({fwd_ctrl, fwd_data} == e, "R3/R4 forward word order", {fwd_ctrl, fwd_data}, e);
                  if (fwd_ctrl && fwd_data == BEGIN_W && seedq.size() != 0)
                     exp_seed = seedq.pop_front();
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1
      chk(ret_ready == 1'b1, "R1 ret_ready", ret_ready, 1);
      chk(fwd_valid == 1'b0, "R1 fwd_valid", fwd_valid, 0);
      chk(err_count == 0 && err_flag == 0, "R1 error state", {err_flag, err_count}, 0);
      chk(blk_count == 0, "R1 blk_count", blk_count, 0);

      // stall: forward link blocked, two blocks pushed
      mon_on = 1'b1;
      hold   = 1'b1;
      send_block(32'h1234_5678, '0, 1'b0, 1);
      send_block(32'hCAFE_0001, '0, 1'b0, 0);
      repeat (3) @(negedge clk);
      #2;
      chk(ret_ready == 1'b0, "R2 ret_ready low with both buffers full", ret_ready, 0);
      chk(fwd_valid && fwd_ctrl && fwd_data == BEGIN_W, "R4 start word waiting",
          {fwd_valid, fwd_ctrl, fwd_data}, {2'b11, BEGIN_W});
      held = fwd_data;
      repeat (2) @(negedge clk);
      #2;
      chk(fwd_valid && fwd_data == held, "R5 word held under backpressure", fwd_data, held);
      hold = 1'b0;
      wait (expq.size() == 0);
      repeat (6) @(negedge clk);
      #2;
      chk(blk_count == 2, "R9 blocks after stall", blk_count, 2);
      chk(err_count == 0 && !err_flag, "R6 clean blocks give no error", err_count, 0);

      // back-to-back burst, forward always ready
      fast = 1'b1;
      for (int b = 0; b < 3; b++) send_block($urandom | 32'h1, '0, 1'b0, 0);
      wait (expq.size() == 0);
      repeat (6) @(negedge clk);
      #2;
      chk(blk_count == 5, "R3 burst blocks", blk_count, 5);
      fast = 1'b0;

      // random traffic with one bad word and one seed mismatch
      for (int b = 0; b < 16; b++)
         send_block($urandom | 32'h1, (b == 5) ? L'(8) : '0, b == 9, 3);
      wait (expq.size() == 0);
      repeat (6) @(negedge clk);
      #2;
      chk(blk_count == 21, "R9 random blocks", blk_count, 21);
      chk(err_count == 2, "R6/R7 one data error and one seed error", err_count, 2);
      chk(err_flag == 1'b1, "R8 flag set", err_flag, 1);

      // clean block afterwards: flag stays, count unchanged
      send_block(32'h0BAD_F00D, '0, 1'b0, 0);
      wait (expq.size() == 0);
      repeat (6) @(negedge clk);
      #2;
      chk(err_flag == 1'b1, "R8 flag sticky", err_flag, 1);
      chk(err_count == 2, "R6 clean block adds nothing", err_count, 2);

      // every non-seed word corrupted: 7 more errors, saturates at 7
      send_block(32'h7777_0003, {{(L-1){1'b1}}, 1'b0}, 1'b0, 0);
      wait (expq.size() == 0);
      repeat (6) @(negedge clk);
      #2;
      chk(err_count == 3'd7, "R8 err_count saturates", err_count, 7);
      chk(blk_count == 23, "R9 final block count", blk_count, 23);
      chk(ret_ready == 1'b1 && fwd_valid == 1'b0, "R2 idle after drain",
          {ret_ready, fwd_valid}, 2'b10);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule